// File: doc/BRIEF.md
# Compressed Instruction Field Decoder (RV32 integer subset)

This block takes one 16-bit compressed RV32 instruction halfword and breaks it into a decoded bundle. The bundle holds an operation code, the destination and two source register indices, a 32-bit immediate reassembled from its scattered bit positions and extended, and a flag for illegal or reserved encodings. It covers the three compressed quadrants for the integer subset only. Floating-point encodings and encodings that exist only on 64-bit or 128-bit machines are reported as illegal. A halfword whose low two bits are 11 is not a compressed instruction. It is flagged as such and not decoded.

A fetch or predecode stage places the block after its halfword aligner and feeds the bundle to the issue logic. The parameter `REG_OUT` sets whether the bundle leaves the block combinationally or through one register stage. The register loads only when the input is marked valid and keeps its contents otherwise. `IMM_W` sets the width of the immediate output. Its value must be at least 18 so that the widest signed immediate, the upper-immediate load, fits.

Top module: `cdec16_top`

## Requirements
- R1: Bits [1:0] pick the quadrant (00, 01, 10) and bits [15:13] pick the operation within it. Operation codes on `op_o`: 0 none, 1 LW, 2 SW, 3 ADDI, 4 JAL, 5 LI, 6 ADDI16SP, 7 LUI, 8 SRLI, 9 SRAI, 10 ANDI, 11 SUB, 12 XOR, 13 OR, 14 AND, 15 J, 16 BEQZ, 17 BNEZ, 18 SLLI, 19 LWSP, 20 JR, 21 MV, 22 EBREAK, 23 JALR, 24 ADD, 25 SWSP, 26 ADDI4SPN. Unused register fields read 0. HINT forms (register 0 as destination, or ADDI with a zero immediate) decode as legal.
- R2: An all-zero halfword is illegal. Whenever `bad_o` is 1, `op_o`, every register index and the immediate are all 0.
- R3: A 3-bit compact register field at bits [9:7] or [4:2] names register 8 plus the field value.
- R4: ADDI4SPN reads x2 and takes a zero-extended immediate, with bits 12:11 giving imm[5:4], bits 10:7 giving imm[9:6], bit 6 giving imm[2] and bit 5 giving imm[3]. A zero immediate is reserved.
- R5: LW and SW take a zero-extended offset, with bits 12:10 giving imm[5:3], bit 6 giving imm[2] and bit 5 giving imm[6].
- R6: J and JAL take a sign-extended even offset scattered over bits 12:2 (bit 12 sign/imm[11], 11 imm[4], 10:9 imm[9:8], 8 imm[10], 7 imm[6], 6 imm[7], 5:3 imm[3:1], 2 imm[5]). JAL writes x1 and J writes no register.
- R7: BEQZ and BNEZ compare a compact rs1 with zero using an offset sign-extended from imm[8], where bit 12 gives imm[8], bits 11:10 imm[4:3], bits 6:5 imm[7:6], bits 4:3 imm[2:1] and bit 2 imm[5].
- R8: In quadrant 1 with bits [15:13]=011, a destination of 2 selects ADDI16SP. Its immediate is sign-extended from imm[9], with bit 12 giving imm[9], bit 6 imm[4], bit 5 imm[6], bits 4:3 imm[8:7] and bit 2 imm[5]. Any other destination selects LUI, with the value {bit12, bits 6:2} sign-extended and shifted left by 12. A zero immediate is reserved in both forms.
- R9: In quadrant 1 with bits [15:13]=100, bits [11:10] select SRLI, SRAI, ANDI or a register group. In that group, bits [6:5] select SUB, XOR, OR or AND. Bit 12 set in the group, or in any shift, is illegal.
- R10: In quadrant 2 with bits [15:13]=100, the forms are: bit 12 clear with rs2 field 0 gives JR; bit 12 clear with rs2 nonzero gives MV; bit 12 set with both fields 0 gives EBREAK; bit 12 set with rs2 field 0 gives JALR; otherwise the result is ADD. JR with rs1 field 0 is reserved, and JALR writes x1.
- R11: LWSP (bit 12 imm[5], bits 6:4 imm[4:2], bits 3:2 imm[7:6]) and SWSP (bits 12:9 imm[5:2], bits 8:7 imm[7:6], rs2 at bits 6:2) address off x2 with zero-extended offsets. LWSP with destination 0 is reserved. SLLI with bit 12 set is illegal.
- R12: Quadrant 0 with bits [15:13] of 001, 011, 100, 101 or 111, and quadrant 2 with 001, 011, 101 or 111, are illegal.
- R13: A halfword with bits [1:0]=11 sets `nocmp_o`, keeps `bad_o` at 0 and gives operation code 0. `half_o` always carries the halfword that produced the bundle.
- R14: With `REG_OUT`=1, reset clears every output. The bundle loads in the cycle after a clock edge that sees `in_valid` high, with `out_valid` high for that cycle. It holds unchanged while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Halfword on `half_i` is to be decoded |
| half_i | input | 16 | Instruction halfword |
| out_valid | output | 1 | Bundle is fresh this cycle |
| half_o | output | 16 | Halfword that produced the bundle |
| op_o | output | 5 | Operation code (R1) |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| imm_o | output | IMM_W | Reassembled, extended immediate |
| bad_o | output | 1 | Illegal or reserved encoding |
| nocmp_o | output | 1 | Halfword is not a compressed instruction |

## Verification
The decoder keeps no state apart from the output register. A wrong bit in a reassembly permutation therefore shows up in the very bundle produced for the first halfword that has that bit set. The stimulus sets single scattered bits one at a time so that every swapped pair of positions yields a distinct immediate. A wrong legality decision shows up at the ports as a nonzero bundle with `bad_o` low, or as a zeroed bundle with `bad_o` high, one register stage after the offending halfword. A register that loads while `in_valid` is low shows up one cycle later as a changed bundle.

// File: rtl/cdec16_pkg.sv
package cdec16_pkg;

   typedef enum logic [4:0] {
      K_NONE = 5'd0,  K_LW    = 5'd1,  K_SW    = 5'd2,  K_ADDI  = 5'd3,
      K_JAL  = 5'd4,  K_LI    = 5'd5,  K_SPADJ = 5'd6,  K_LUI   = 5'd7,
      K_SRL  = 5'd8,  K_SRA   = 5'd9,  K_ANDI  = 5'd10, K_SUB   = 5'd11,
      K_XOR  = 5'd12, K_OR    = 5'd13, K_AND   = 5'd14, K_J     = 5'd15,
      K_BEQZ = 5'd16, K_BNEZ  = 5'd17, K_SLL   = 5'd18, K_LDSP  = 5'd19,
      K_JR   = 5'd20, K_MV    = 5'd21, K_BRK   = 5'd22, K_JALR  = 5'd23,
      K_ADD  = 5'd24, K_STSP  = 5'd25, K_SPADD = 5'd26
   } kind_e;

   typedef struct packed {
      logic [4:0]  op;
      logic [4:0]  rd;
      logic [4:0]  rs1;
      logic [4:0]  rs2;
      logic [31:0] imm;
      logic        bad;
   } bundle_t;

   localparam int unsigned BUNDLE_W = $bits(bundle_t);

   function automatic logic [4:0] short_reg(input logic [2:0] f);
      return {2'b01, f};
   endfunction

   function automatic logic [31:0] sext6(input logic [15:0] h);
      return {{26{h[12]}}, h[12], h[6:2]};
   endfunction

   function automatic bundle_t squash(input bundle_t b);
      bundle_t z;
      z = '0;
      z.bad = 1'b1;
      return b.bad ? z : b;
   endfunction

endpackage

// File: rtl/cdec16_q0.sv
module cdec16_q0
   import cdec16_pkg::*;
(
   input  logic [15:0] h,
   output bundle_t     d
);
   bundle_t raw;

   always_comb begin
      raw = '0;
      unique case (h[15:13])
         3'b000: begin
            raw.op  = K_SPADD;
            raw.rd  = short_reg(h[4:2]);
            raw.rs1 = 5'd2;
            raw.imm = {22'b0, h[10:7], h[12:11], h[5], h[6], 2'b00};
            raw.bad = (h[12:5] == 8'd0);
         end
         3'b010: begin
            raw.op  = K_LW;
            raw.rd  = short_reg(h[4:2]);
            raw.rs1 = short_reg(h[9:7]);
            raw.imm = {25'b0, h[5], h[12:10], h[6], 2'b00};
         end
         3'b110: begin
            raw.op  = K_SW;
            raw.rs1 = short_reg(h[9:7]);
            raw.rs2 = short_reg(h[4:2]);
            raw.imm = {25'b0, h[5], h[12:10], h[6], 2'b00};
         end
         default: raw.bad = 1'b1;
      endcase
      d = squash(raw);
   end
endmodule

// File: rtl/cdec16_q1.sv
module cdec16_q1
   import cdec16_pkg::*;
(
   input  logic [15:0] h,
   output bundle_t     d
);
   bundle_t    raw;
   logic [4:0] cr1;
   logic       imm_zero;

   assign cr1      = short_reg(h[9:7]);
   assign imm_zero = ({h[12], h[6:2]} == 6'd0);

   always_comb begin
      raw = '0;
      unique case (h[15:13])
         3'b000, 3'b010: begin
            raw.op  = (h[14]) ? K_LI : K_ADDI;
            raw.rd  = h[11:7];
            raw.rs1 = (h[14]) ? 5'd0 : h[11:7];
            raw.imm = sext6(h);
         end
         3'b001, 3'b101: begin
            raw.op  = (h[15]) ? K_J : K_JAL;
            raw.rd  = (h[15]) ? 5'd0 : 5'd1;
            raw.imm = {{20{h[12]}}, h[12], h[8], h[10:9], h[6], h[7], h[2],
                       h[11], h[5:3], 1'b0};
         end
         3'b011: begin
            raw.bad = imm_zero;
            if (h[11:7] == 5'd2) begin
               raw.op  = K_SPADJ;
               raw.rd  = 5'd2;
               raw.rs1 = 5'd2;
               raw.imm = {{22{h[12]}}, h[12], h[4:3], h[5], h[2], h[6], 4'b0};
            end else begin
               raw.op  = K_LUI;
               raw.rd  = h[11:7];
               raw.imm = {{14{h[12]}}, h[12], h[6:2], 12'b0};
            end
         end
         3'b100: begin
            raw.rd  = cr1;
            raw.rs1 = cr1;
            unique case (h[11:10])
               2'b00, 2'b01: begin
                  raw.op  = (h[10]) ? K_SRA : K_SRL;
                  raw.imm = {26'b0, h[12], h[6:2]};
                  raw.bad = h[12];
               end
               2'b10: begin
                  raw.op  = K_ANDI;
                  raw.imm = sext6(h);
               end
               default: begin
                  raw.rs2 = short_reg(h[4:2]);
                  raw.bad = h[12];
                  unique case (h[6:5])
                     2'b00:   raw.op = K_SUB;
                     2'b01:   raw.op = K_XOR;
                     2'b10:   raw.op = K_OR;
                     default: raw.op = K_AND;
                  endcase
               end
            endcase
         end
         default: begin
            raw.op  = (h[13]) ? K_BNEZ : K_BEQZ;
            raw.rs1 = cr1;
            raw.imm = {{23{h[12]}}, h[12], h[6:5], h[2], h[11:10], h[4:3], 1'b0};
         end
      endcase
      d = squash(raw);
   end
endmodule

// File: rtl/cdec16_q2.sv
module cdec16_q2
   import cdec16_pkg::*;
(
   input  logic [15:0] h,
   output bundle_t     d
);
   bundle_t    raw;
   logic [4:0] fa;
   logic [4:0] fb;

   assign fa = h[11:7];
   assign fb = h[6:2];

   always_comb begin
      raw = '0;
      unique case (h[15:13])
         3'b000: begin
            raw.op  = K_SLL;
            raw.rd  = fa;
            raw.rs1 = fa;
            raw.imm = {26'b0, h[12], fb};
            raw.bad = h[12];
         end
         3'b010: begin
            raw.op  = K_LDSP;
            raw.rd  = fa;
            raw.rs1 = 5'd2;
            raw.imm = {24'b0, h[3:2], h[12], h[6:4], 2'b00};
            raw.bad = (fa == 5'd0);
         end
         3'b100: begin
            if (!h[12]) begin
               if (fb == 5'd0) begin
                  raw.op  = K_JR;
                  raw.rs1 = fa;
                  raw.bad = (fa == 5'd0);
               end else begin
                  raw.op  = K_MV;
                  raw.rd  = fa;
                  raw.rs2 = fb;
               end
            end else if (fb == 5'd0) begin
               if (fa == 5'd0) begin
                  raw.op = K_BRK;
               end else begin
                  raw.op  = K_JALR;
                  raw.rd  = 5'd1;
                  raw.rs1 = fa;
               end
            end else begin
               raw.op  = K_ADD;
               raw.rd  = fa;
               raw.rs1 = fa;
               raw.rs2 = fb;
            end
         end
         3'b110: begin
            raw.op  = K_STSP;
            raw.rs1 = 5'd2;
            raw.rs2 = fb;
            raw.imm = {24'b0, h[8:7], h[12:9], 2'b00};
         end
         default: raw.bad = 1'b1;
      endcase
      d = squash(raw);
   end
endmodule

// File: rtl/cdec16_top.sv
module cdec16_top
   import cdec16_pkg::*;
#(
   parameter int unsigned IMM_W   = 32,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [15:0]      half_i,
   output logic             out_valid,
   output logic [15:0]      half_o,
   output logic [4:0]       op_o,
   output logic [4:0]       rd_o,
   output logic [4:0]       rs1_o,
   output logic [4:0]       rs2_o,
   output logic [IMM_W-1:0] imm_o,
   output logic             bad_o,
   output logic             nocmp_o
);
   localparam int unsigned SRC_W = 32;

   if (IMM_W < 18) begin : g_width_check
      $error("cdec16_top: IMM_W must be at least 18");
   end

   bundle_t          b0, b1, b2, sel;
   logic             nc;
   logic [IMM_W-1:0] imm_ext;

   cdec16_q0 u_q0 (.h(half_i), .d(b0));
   cdec16_q1 u_q1 (.h(half_i), .d(b1));
   cdec16_q2 u_q2 (.h(half_i), .d(b2));

   always_comb begin
      nc = 1'b0;
      unique case (half_i[1:0])
         2'b00:   sel = b0;
         2'b01:   sel = b1;
         2'b10:   sel = b2;
         default: begin
            sel = '0;
            nc  = 1'b1;
         end
      endcase
   end

   always_comb begin
      for (int i = 0; i < int'(IMM_W); i++) begin
         imm_ext[i] = (i < int'(SRC_W)) ? sel.imm[i] : sel.imm[SRC_W-1];
      end
   end

   if (REG_OUT) begin : g_reg
      logic             v_q, bad_q, nc_q;
      logic [15:0]      h_q;
      logic [4:0]       op_q, rd_q, rs1_q, rs2_q;
      logic [IMM_W-1:0] imm_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q   <= 1'b0;
            h_q   <= '0;
            op_q  <= '0;
            rd_q  <= '0;
            rs1_q <= '0;
            rs2_q <= '0;
            imm_q <= '0;
            bad_q <= 1'b0;
            nc_q  <= 1'b0;
         end else begin
            v_q <= in_valid;
            if (in_valid) begin
               h_q   <= half_i;
               op_q  <= sel.op;
               rd_q  <= sel.rd;
               rs1_q <= sel.rs1;
               rs2_q <= sel.rs2;
               imm_q <= imm_ext;
               bad_q <= sel.bad;
               nc_q  <= nc;
            end
         end
      end

      assign out_valid = v_q;
      assign half_o    = h_q;
      assign op_o      = op_q;
      assign rd_o      = rd_q;
      assign rs1_o     = rs1_q;
      assign rs2_o     = rs2_q;
      assign imm_o     = imm_q;
      assign bad_o     = bad_q;
      assign nocmp_o   = nc_q;

      // R14
      load_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R14
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(op_q) && $stable(imm_q) && $stable(h_q)));
      // R2
      bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bad_q |-> (op_q == 5'd0 && imm_q == '0 && rd_q == 5'd0 && rs1_q == 5'd0));
      // R13
      nocmp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         nc_q |-> (!bad_q && op_q == 5'd0 && h_q[1:0] == 2'b11));
      // R3
      short_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (op_q == K_LW || op_q == K_SW) |-> (rs1_q[4:3] == 2'b01));
      // R6
      link_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (op_q == K_JAL || op_q == K_JALR) |-> (rd_q == 5'd1));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign half_o    = half_i;
      assign op_o      = sel.op;
      assign rd_o      = sel.rd;
      assign rs1_o     = sel.rs1;
      assign rs2_o     = sel.rs2;
      assign imm_o     = imm_ext;
      assign bad_o     = sel.bad;
      assign nocmp_o   = nc;
   end

endmodule

// File: tb/sim_cdec16_top.sv
module sim_cdec16_top;
   localparam int NV = 47;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] half_i = '0;
   logic        out_valid, bad_o, nocmp_o;
   logic [15:0] half_o;
   logic [4:0]  op_o, rd_o, rs1_o, rs2_o;
   logic [31:0] imm_o;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   cdec16_top u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_i(half_i),
      .out_valid(out_valid), .half_o(half_o), .op_o(op_o), .rd_o(rd_o),
      .rs1_o(rs1_o), .rs2_o(rs2_o), .imm_o(imm_o), .bad_o(bad_o),
      .nocmp_o(nocmp_o)
   );

   // {req, halfword, op, rd, rs1, rs2, imm, bad, nocmp}
   localparam logic [77:0] TBL [NV] = '{
      {8'd2,  16'h0000, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R2
      {8'd4,  16'h0024, 5'd26, 5'd9,  5'd2,  5'd0,  32'd8,        1'b0, 1'b0}, // R4
      {8'd4,  16'h1000, 5'd26, 5'd8,  5'd2,  5'd0,  32'd32,       1'b0, 1'b0}, // R4
      {8'd4,  16'h079C, 5'd26, 5'd15, 5'd2,  5'd0,  32'd960,      1'b0, 1'b0}, // R4 R3
      {8'd4,  16'h0004, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R4
      {8'd5,  16'h454C, 5'd1,  5'd11, 5'd10, 5'd0,  32'd12,       1'b0, 1'b0}, // R5
      {8'd5,  16'h4020, 5'd1,  5'd8,  5'd8,  5'd0,  32'd64,       1'b0, 1'b0}, // R5 R3
      {8'd5,  16'hDC3C, 5'd2,  5'd0,  5'd8,  5'd15, 32'd120,      1'b0, 1'b0}, // R5
      {8'd12, 16'h2000, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R12
      {8'd12, 16'h8000, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R12
      {8'd1,  16'h12FD, 5'd3,  5'd5,  5'd5,  5'd0,  32'hFFFFFFFF, 1'b0, 1'b0}, // R1
      {8'd1,  16'h0001, 5'd3,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0, 1'b0}, // R1 hint
      {8'd6,  16'h3001, 5'd4,  5'd1,  5'd0,  5'd0,  32'hFFFFF800, 1'b0, 1'b0}, // R6
      {8'd6,  16'h2881, 5'd4,  5'd1,  5'd0,  5'd0,  32'd80,       1'b0, 1'b0}, // R6
      {8'd6,  16'hA10D, 5'd15, 5'd0,  5'd0,  5'd0,  32'd1058,     1'b0, 1'b0}, // R6
      {8'd1,  16'h4515, 5'd5,  5'd10, 5'd0,  5'd0,  32'd5,        1'b0, 1'b0}, // R1
      {8'd8,  16'h7141, 5'd6,  5'd2,  5'd2,  5'd0,  32'hFFFFFE10, 1'b0, 1'b0}, // R8
      {8'd8,  16'h6101, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R8
      {8'd8,  16'h6185, 5'd7,  5'd3,  5'd0,  5'd0,  32'h00001000, 1'b0, 1'b0}, // R8
      {8'd8,  16'h7185, 5'd7,  5'd3,  5'd0,  5'd0,  32'hFFFE1000, 1'b0, 1'b0}, // R8
      {8'd8,  16'h6181, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R8
      {8'd9,  16'h808D, 5'd8,  5'd9,  5'd9,  5'd0,  32'd3,        1'b0, 1'b0}, // R9
      {8'd9,  16'h908D, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R9
      {8'd9,  16'h847D, 5'd9,  5'd8,  5'd8,  5'd0,  32'd31,       1'b0, 1'b0}, // R9
      {8'd9,  16'h9A79, 5'd10, 5'd12, 5'd12, 5'd0,  32'hFFFFFFFE, 1'b0, 1'b0}, // R9
      {8'd9,  16'h8E99, 5'd11, 5'd13, 5'd13, 5'd14, 32'h0,        1'b0, 1'b0}, // R9
      {8'd9,  16'h8C21, 5'd12, 5'd8,  5'd8,  5'd8,  32'h0,        1'b0, 1'b0}, // R9
      {8'd9,  16'h8C41, 5'd13, 5'd8,  5'd8,  5'd8,  32'h0,        1'b0, 1'b0}, // R9
      {8'd9,  16'h8C61, 5'd14, 5'd8,  5'd8,  5'd8,  32'h0,        1'b0, 1'b0}, // R9
      {8'd9,  16'h9C01, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R9
      {8'd7,  16'hD08D, 5'd16, 5'd0,  5'd9,  5'd0,  32'hFFFFFF22, 1'b0, 1'b0}, // R7
      {8'd7,  16'hE841, 5'd17, 5'd0,  5'd8,  5'd0,  32'd144,      1'b0, 1'b0}, // R7
      {8'd11, 16'h0386, 5'd18, 5'd7,  5'd7,  5'd0,  32'd1,        1'b0, 1'b0}, // R11
      {8'd11, 16'h1386, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R11
      {8'd11, 16'h5096, 5'd19, 5'd1,  5'd2,  5'd0,  32'd100,      1'b0, 1'b0}, // R11
      {8'd11, 16'h4002, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R11
      {8'd11, 16'hC322, 5'd25, 5'd0,  5'd2,  5'd8,  32'd132,      1'b0, 1'b0}, // R11
      {8'd10, 16'h8082, 5'd20, 5'd0,  5'd1,  5'd0,  32'h0,        1'b0, 1'b0}, // R10
      {8'd10, 16'h8002, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R10
      {8'd10, 16'h852E, 5'd21, 5'd10, 5'd0,  5'd11, 32'h0,        1'b0, 1'b0}, // R10
      {8'd10, 16'h802E, 5'd21, 5'd0,  5'd0,  5'd11, 32'h0,        1'b0, 1'b0}, // R10 hint
      {8'd10, 16'h9002, 5'd22, 5'd0,  5'd0,  5'd0,  32'h0,        1'b0, 1'b0}, // R10
      {8'd10, 16'h9282, 5'd23, 5'd1,  5'd5,  5'd0,  32'h0,        1'b0, 1'b0}, // R10
      {8'd10, 16'h952E, 5'd24, 5'd10, 5'd10, 5'd11, 32'h0,        1'b0, 1'b0}, // R10
      {8'd12, 16'h2002, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R12
      {8'd12, 16'hE002, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b1, 1'b0}, // R12
      {8'd13, 16'h0013, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0, 1'b1}  // R13
   };

   function automatic logic [69:0] got_vec();
      return {half_o, op_o, rd_o, rs1_o, rs2_o, imm_o, bad_o, nocmp_o};
   endfunction

   task automatic check(input string tag, input logic [69:0] act, input logic [69:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [69:0] last;
      repeat (3) @(negedge clk);
      // R14 reset state
      check("R14 reset", {out_valid, got_vec()}, '0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         half_i   = TBL[i][69:54];
         in_valid = 1'b1;
         @(negedge clk);
         check($sformatf("R%0d vec %0d", TBL[i][77:70], i),
               {out_valid, got_vec()}, {1'b1, TBL[i][69:0]});
      end
      last = got_vec();

      // R14 hold while idle
      in_valid = 1'b0;
      half_i   = 16'h12FD;
      @(negedge clk);
      check("R14 hold", {out_valid, got_vec()}, {1'b0, last});
      @(negedge clk);
      check("R14 hold2", {out_valid, got_vec()}, {1'b0, last});

      // R14 single-cycle valid then idle
      half_i   = 16'h4515;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      half_i   = 16'h0000;
      check("R14 load", {out_valid, op_o, rd_o}, {1'b1, 5'd5, 5'd10});
      @(negedge clk);
      check("R14 drop", {out_valid, op_o, rd_o, bad_o}, {1'b0, 5'd5, 5'd10, 1'b0});

      // R14 reset mid-run clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R14 rerst", {out_valid, got_vec()}, '0);
      rst_n = 1'b1;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule